// File: doc/BRIEF.md
# Multi-function pad control cell

This block is the control logic of one I/O pad. A single 16-bit configuration word, reached over a small write/read register bus, decides which of eight internal peripheral signal sets owns the pad, where the pad's pull resistors take their orders from, how strongly and how fast the pad drives, and what the pad does while the chip sleeps.

Each peripheral offers three signals to the cell: output data, output enable and a pull request (up and down). The cell selects one set and resolves the pull controls, so the pad can never be pulled both ways. When the low-power input is high and the configuration asks for it, the cell replaces the peripheral's data and enable with values held in the configuration word. All pad-side controls leave the cell through registers. The pad input is returned to every peripheral unchanged.

Top module: `padmux_cell`

## Requirements
- R1: After synchronous reset the configuration reads 0x0000_0800: function 0, drive code 2, peripheral-controlled pulls, no low-power override. On the first cycle after reset the pad follows function 0 with drive code 2.
- R2: A write stores bits 15:4 and 2:0 of the bus data. Bit 3 and bits 31:16 always read as zero, whatever was written. Read data appears on the clock edge after the read request.
- R3: Bits 2:0 pick the function number 0..7. The pad data and pad enable equal that function's output data and output enable, registered once: they change on the first clock edge after the inputs change.
- R4: When bit 15 is 0, the pull-up and pull-down come from the selected function's pull requests. When bit 15 is 1, bit 14 requests the pull-up and bit 13 requests the pull-down.
- R5: If the pull-up and pull-down are both requested from either source, only the pull-up is applied.
- R6: When the low-power input is 1 and bit 9 is 1, the pad enable is the inverse of bit 7 and the pad data is bit 8, whatever the peripheral drives. If either condition is 0, the peripheral values are used.
- R7: Bits 12:10 appear unchanged on the 3-bit drive port. The slow-slew flag is 1 only for codes 4 and 6.
- R8: Every bit of the peripheral input bus equals the pad input, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_re | input | 1 | Read request |
| cfg_rdata | output | 32 | Read data, registered |
| lowpwr | input | 1 | Chip is in a low-power state |
| per_out | input | 8 | Output data, one bit per function |
| per_oe | input | 8 | Output enable, one bit per function |
| per_pu | input | 8 | Pull-up request, one bit per function |
| per_pd | input | 8 | Pull-down request, one bit per function |
| per_in | output | 8 | Pad input copied to each function |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Output enable to the pad driver |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| pad_drv | output | 3 | Drive strength code |
| pad_slow | output | 1 | Slow slew-rate flag |

## Verification
The checks assume that reset is held for at least one clock edge before the first access, and that the function select always names one of the eight populated signal sets. They also assume that the low-power input and the peripheral signals are stable around each rising edge. The bench changes every input only on falling edges and releases reset before any register access. It writes a new configuration word one full cycle before it samples outputs that depend on it, so each expected value rests on exactly one register stage.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

  localparam int CFG_W    = 16;
  localparam int AF_W     = 3;
  localparam int DRV_W    = 3;

  // configuration word layout
  typedef struct packed {
    logic             pull_sel;   // 15: 1 = register pulls
    logic             pu_en;      // 14
    logic             pd_en;      // 13
    logic [DRV_W-1:0] drv;        // 12:10
    logic             lp_sel;     // 9
    logic             lp_data;    // 8
    logic             lp_oe_n;    // 7
    logic [2:0]       aux;        // 6:4 stored, read back
    logic             rsv;        // 3 always zero
    logic [AF_W-1:0]  af;         // 2:0
  } pad_cfg_t;

  localparam logic [CFG_W-1:0] CFG_WR_MASK = 16'hFFF7;
  localparam logic [DRV_W-1:0] DRV_RESET   = 3'd2;
  localparam logic [CFG_W-1:0] CFG_RESET   = {3'b000, DRV_RESET, 10'd0};

  function automatic logic drv_is_slow(input logic [DRV_W-1:0] code);
    return (code == 3'd4) || (code == 3'd6);
  endfunction

endpackage

// File: rtl/padmux_cfg_reg.sv
module padmux_cfg_reg
  import padmux_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  input  logic             re,
  output logic [BUS_W-1:0] rdata,
  output pad_cfg_t         cfg
);

  localparam int PAD_W = BUS_W - CFG_W;

  logic unused_hi;
  assign unused_hi = ^wdata[BUS_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= pad_cfg_t'(CFG_RESET);
    end else if (we) begin
      cfg <= pad_cfg_t'(wdata[CFG_W-1:0] & CFG_WR_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= {{PAD_W{1'b0}}, cfg};
    end
  end

endmodule

// File: rtl/padmux_fn_select.sv
module padmux_fn_select
  import padmux_pkg::*;
#(
  parameter int NUM_FUNC = 8
) (
  input  logic [AF_W-1:0]     sel,
  input  logic [NUM_FUNC-1:0] f_out,
  input  logic [NUM_FUNC-1:0] f_oe,
  input  logic [NUM_FUNC-1:0] f_pu,
  input  logic [NUM_FUNC-1:0] f_pd,
  output logic                s_out,
  output logic                s_oe,
  output logic                s_pu,
  output logic                s_pd
);

  logic [NUM_FUNC-1:0] hit;

  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_dec
    assign hit[g] = (sel == AF_W'(g));
  end

  always_comb begin
    s_out = |(hit & f_out);
    s_oe  = |(hit & f_oe);
    s_pu  = |(hit & f_pu);
    s_pd  = |(hit & f_pd);
  end

endmodule

// File: rtl/padmux_drive_out.sv
module padmux_drive_out
  import padmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lowpwr,
  input  logic             s_out,
  input  logic             s_oe,
  input  logic             s_pu,
  input  logic             s_pd,
  input  logic             pull_sel,
  input  logic             pu_en,
  input  logic             pd_en,
  input  logic             lp_sel,
  input  logic             lp_data,
  input  logic             lp_oe_n,
  input  logic [DRV_W-1:0] drv,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_pu,
  output logic             pad_pd,
  output logic [DRV_W-1:0] pad_drv,
  output logic             pad_slow
);

  logic d_out, d_oe, d_pu, d_pd, want_pu, want_pd, lp_active;

  always_comb begin
    want_pu   = pull_sel ? pu_en : s_pu;
    want_pd   = pull_sel ? pd_en : s_pd;
    d_pu      = want_pu;
    d_pd      = want_pd & ~want_pu;
    lp_active = lowpwr & lp_sel;
    d_out     = lp_active ? lp_data  : s_out;
    d_oe      = lp_active ? ~lp_oe_n : s_oe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= 1'b0;
      pad_oe   <= 1'b0;
      pad_pu   <= 1'b0;
      pad_pd   <= 1'b0;
      pad_drv  <= DRV_RESET;
      pad_slow <= 1'b0;
    end else begin
      pad_out  <= d_out;
      pad_oe   <= d_oe;
      pad_pu   <= d_pu;
      pad_pd   <= d_pd;
      pad_drv  <= drv;
      pad_slow <= drv_is_slow(drv);
    end
  end

endmodule

// File: rtl/padmux_cell.sv
module padmux_cell
  import padmux_pkg::*;
#(
  parameter int NUM_FUNC = 8,
  parameter int BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [BUS_W-1:0]    cfg_wdata,
  input  logic                cfg_re,
  output logic [BUS_W-1:0]    cfg_rdata,
  input  logic                lowpwr,
  input  logic [NUM_FUNC-1:0] per_out,
  input  logic [NUM_FUNC-1:0] per_oe,
  input  logic [NUM_FUNC-1:0] per_pu,
  input  logic [NUM_FUNC-1:0] per_pd,
  output logic [NUM_FUNC-1:0] per_in,
  input  logic                pad_in,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                pad_pu,
  output logic                pad_pd,
  output logic [DRV_W-1:0]    pad_drv,
  output logic                pad_slow
);

  pad_cfg_t cfg_q;
  logic     s_out, s_oe, s_pu, s_pd;

  padmux_cfg_reg #(.BUS_W(BUS_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .re    (cfg_re),
    .rdata (cfg_rdata),
    .cfg   (cfg_q)
  );

  padmux_fn_select #(.NUM_FUNC(NUM_FUNC)) u_sel (
    .sel   (cfg_q.af),
    .f_out (per_out),
    .f_oe  (per_oe),
    .f_pu  (per_pu),
    .f_pd  (per_pd),
    .s_out (s_out),
    .s_oe  (s_oe),
    .s_pu  (s_pu),
    .s_pd  (s_pd)
  );

  padmux_drive_out u_drv (
    .clk      (clk),
    .rst      (rst),
    .lowpwr   (lowpwr),
    .s_out    (s_out),
    .s_oe     (s_oe),
    .s_pu     (s_pu),
    .s_pd     (s_pd),
    .pull_sel (cfg_q.pull_sel),
    .pu_en    (cfg_q.pu_en),
    .pd_en    (cfg_q.pd_en),
    .lp_sel   (cfg_q.lp_sel),
    .lp_data  (cfg_q.lp_data),
    .lp_oe_n  (cfg_q.lp_oe_n),
    .drv      (cfg_q.drv),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_drv  (pad_drv),
    .pad_slow (pad_slow)
  );

  // R8: pad input fanned to all functions
  assign per_in = {NUM_FUNC{pad_in}};

endmodule

// File: rtl/padmux_cell_chk.sv
module padmux_cell_chk #(
  parameter int NUM_FUNC = 8,
  parameter int BUS_W    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                lowpwr,
  input logic                cfg_re,
  input logic [BUS_W-1:0]    cfg_rdata,
  input logic [15:0]         cfg_word,
  input logic [NUM_FUNC-1:0] per_out,
  input logic [NUM_FUNC-1:0] per_oe,
  input logic                pad_out,
  input logic                pad_oe,
  input logic                pad_pu,
  input logic                pad_pd,
  input logic [2:0]          pad_drv,
  input logic                pad_slow
);

  a_r1_reset_word: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_word == 16'h0800));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_re |=> (cfg_rdata[BUS_W-1:16] == '0 && cfg_rdata[3] == 1'b0));

  a_r3_route: assert property (@(posedge clk) disable iff (rst)
    !(lowpwr && cfg_word[9]) |=>
      (pad_out == $past(per_out[cfg_word[2:0]]) && pad_oe == $past(per_oe[cfg_word[2:0]])));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    pad_pu |-> !pad_pd);

  a_r6_lp_override: assert property (@(posedge clk) disable iff (rst)
    (lowpwr && cfg_word[9]) |=>
      (pad_oe == !$past(cfg_word[7]) && pad_out == $past(cfg_word[8])));

  a_r7_drive_code: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_drv == $past(cfg_word[12:10])));

  a_r7_slow_flag: assert property (@(posedge clk) disable iff (rst)
    pad_slow == (pad_drv == 3'd4 || pad_drv == 3'd6));

endmodule

bind padmux_cell padmux_cell_chk #(.NUM_FUNC(NUM_FUNC), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lowpwr    (lowpwr),
  .cfg_re    (cfg_re),
  .cfg_rdata (cfg_rdata),
  .cfg_word  (cfg_q),
  .per_out   (per_out),
  .per_oe    (per_oe),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .pad_drv   (pad_drv),
  .pad_slow  (pad_slow)
);

// File: tb/test_padmux_cell.sv
module test_padmux_cell;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0, lowpwr = 1'b0, pad_in = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  per_out = '0, per_oe = '0, per_pu = '0, per_pd = '0, per_in;
  logic        pad_out, pad_oe, pad_pu, pad_pd, pad_slow;
  logic [2:0]  pad_drv;

  always #5 clk = ~clk;

  padmux_cell i_padmux_cell (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .lowpwr(lowpwr),
    .per_out(per_out), .per_oe(per_oe), .per_pu(per_pu), .per_pd(per_pd),
    .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv(pad_drv), .pad_slow(pad_slow)
  );

  typedef struct packed {
    logic        is_rd;
    logic [31:0] rdata;
    logic [7:0]  io;   // {out, oe, pu, pd, drv[2:0], slow}
    int          due;
  } item_t;

  item_t q[$];
  string tagq[$];
  int    cyc = 0;
  int    n_run = 0, n_fail = 0;
  logic [15:0] shadow = 16'h0800;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] model(input logic [15:0] c, input logic [7:0] po,
      input logic [7:0] poe, input logic [7:0] ppu, input logic [7:0] ppd, input logic lp);
    logic o, e, u, d;
    logic [2:0] f, dc;
    f  = c[2:0];
    o  = po[f];
    e  = poe[f];
    u  = c[15] ? c[14] : ppu[f];
    d  = c[15] ? c[13] : ppd[f];
    if (u) d = 1'b0;
    if (lp && c[9]) begin
      e = ~c[7];
      o = c[8];
    end
    dc = c[12:10];
    return {o, e, u, d, dc, (dc == 3'd4 || dc == 3'd6)};
  endfunction

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      string tg;
      it = q.pop_front();
      tg = tagq.pop_front();
      n_run++;
      if (it.is_rd) begin
        if (cfg_rdata !== it.rdata) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", tg, cfg_rdata, it.rdata);
        end
      end else begin
        if ({pad_out, pad_oe, pad_pu, pad_pd, pad_drv, pad_slow} !== it.io) begin
          n_fail++;
          $display("FAIL %s pad actual=%b expected=%b", tg,
                   {pad_out, pad_oe, pad_pu, pad_pd, pad_drv, pad_slow}, it.io);
        end
      end
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = v[15:0] & 16'hFFF7;
  endtask

  task automatic rd(input string tg);
    item_t it;
    @(negedge clk);
    cfg_re = 1'b1;
    it = '{is_rd: 1'b1, rdata: {16'h0, shadow}, io: 8'h0, due: cyc + 1};
    q.push_back(it);
    tagq.push_back(tg);
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic io(input string tg, input logic [7:0] po, input logic [7:0] poe,
                    input logic [7:0] ppu, input logic [7:0] ppd, input logic lp);
    item_t it;
    @(negedge clk);
    per_out = po; per_oe = poe; per_pu = ppu; per_pd = ppd; lowpwr = lp;
    it = '{is_rd: 1'b0, rdata: 32'h0, io: model(shadow, po, poe, ppu, ppd, lp), due: cyc + 1};
    q.push_back(it);
    tagq.push_back(tg);
  endtask

  task automatic fan(input logic v);
    @(negedge clk);
    pad_in = v;
    #1;
    n_run++;
    if (per_in !== {8{v}}) begin  // R8
      n_fail++;
      $display("FAIL R8 per_in actual=%b expected=%b", per_in, {8{v}});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset word and function 0 routing
    rd("R1");
    io("R1", 8'h01, 8'h01, 8'h00, 8'h01, 1'b0);
    // R2: reserved bits read zero
    wr(32'hFFFF_FFFF);
    rd("R2");
    wr(32'h0000_0008);
    rd("R2");
    wr(32'hA5A5_0076);
    rd("R2");
    // R3: each function routed
    for (int f = 0; f < 8; f++) begin
      wr(32'(f) | (32'd2 << 10));
      io("R3", 8'(1 << f), ~8'(1 << f), 8'h00, 8'h00, 1'b0);
      io("R3", ~8'(1 << f), 8'(1 << f), 8'h00, 8'h00, 1'b0);
    end
    // R4: peripheral pulls, function 5
    wr(32'h0000_0805);
    io("R4", 8'h00, 8'h00, 8'h20, 8'h00, 1'b0);
    io("R4", 8'h00, 8'h00, 8'hDF, 8'h20, 1'b0);
    io("R5", 8'h00, 8'h00, 8'h20, 8'h20, 1'b0);
    // R4: register pulls override peripheral
    wr(32'h0000_8805);
    io("R4", 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0);
    wr(32'h0000_C805);
    io("R4", 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0);
    wr(32'h0000_A805);
    io("R4", 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0);
    wr(32'h0000_E805);
    io("R5", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    // R6: low-power override, function 3
    wr(32'h0000_0B03);            // bit9, bit8 set, bit7 clear
    io("R6", 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
    io("R6", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    wr(32'h0000_0A83);            // bit9, bit7 set, bit8 clear
    io("R6", 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1);
    wr(32'h0000_0903);            // bit9 clear: no override
    io("R6", 8'h08, 8'h00, 8'h00, 8'h00, 1'b1);
    // R7: all drive codes
    for (int d = 0; d < 8; d++) begin
      wr(32'(d) << 10);
      io("R7", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    end
    // R8: fan-out
    fan(1'b1);
    fan(1'b0);
    fan(1'b1);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule